// File: doc/BRIEF.md
# Pulsed Two-Stage Row and Column Select Decoder

This block turns a 10-bit memory address into the select lines of a 128-row, 8-way column-multiplexed bit-cell array. The upper seven address bits choose a row. The lower three bits choose one of eight column positions inside each output bit. Row decoding happens in two stages. Three predecoders (one 3-to-8 and two 2-to-4) each see a slice of the row field. A final AND of one output from each predecoder then drives a word line, and only while the word-line timing pulse is high.

Every word line therefore sits low between accesses. An access only has to raise one line and never has to clear the previous one. The address is captured on the clock edge that first sees the pulse high. In that first cycle the live address drives the decode directly. For the rest of the pulse the captured copy drives it, so address changes during a pulse cannot move the selected row or column. A chip enable forces every word line and every column select low.

Top module: `row_pulse_decoder`

## Requirements
- R1: While the pulse and enable are high, the only word line driven high is the one whose index equals addr[9:3] read as an unsigned number; the 3-to-8 predecoder sees addr[9:7], one 2-to-4 predecoder sees addr[6:5], and the other sees addr[4:3].
- R2: Whenever the pulse input is low, all 128 word lines are low.
- R3: At most one word line is high in any cycle, and exactly one is high while pulse and enable are both high.
- R4: While enable is high, exactly one column select is high: col_sel[k] with k equal to the 3-bit value at addr[2:0] of the selected address.
- R5: While enable is low, every word line and every column select is low, whatever the pulse and address do.
- R6: The address is captured on the first clock edge at which the pulse is sampled high. Address changes later in the same pulse change neither the word lines nor the column select.
- R7: After reset, the captured address is zero. With the pulse low and enable high, all word lines are low and col_sel equals 8'b0000_0001.
- R8: Each new pulse, even one that follows a single low cycle, decodes the address present when that pulse begins. It does not decode the one captured for the previous pulse.
- R9: Between pulses, with enable high, the column select keeps showing the column of the most recently captured address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address capture register and the pulse history are updated on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Access address; bits [9:3] select the row, bits [2:0] select the column |
| vcp | input | 1 | Word-line timing pulse; word lines may only be high while it is high |
| en | input | 1 | Chip enable, active high |
| wl | output | 128 | Word lines, one per row |
| col_sel | output | 8 | One-hot column multiplexer select |

## Verification
Suppose the captured address register or the pulse-start history holds a wrong value. The first symptom is a word line or column select that changes in the second cycle of a pulse when the address input moves. Another is a pulse that raises a row belonging to the previous access. Both appear at the ports within one clock of the fault. A predecoder slice wired to the wrong address bits shows up on the very first pulse whose row field has distinct bits in the affected group. A fault in the pulse or enable gating shows up as a word line high outside a pulse, or as two lines high together, in the same cycle.

// File: rtl/row_pulse_decoder.sv
module row_pulse_decoder #(
  parameter int HI_W  = 3,
  parameter int MID_W = 2,
  parameter int LO_W  = 2,
  parameter int COL_W = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [HI_W+MID_W+LO_W+COL_W-1:0]          addr,
  input  logic                                      vcp,
  input  logic                                      en,
  output logic [(1<<(HI_W+MID_W+LO_W))-1:0]         wl,
  output logic [(1<<COL_W)-1:0]                     col_sel
);

  localparam int ROW_W  = HI_W + MID_W + LO_W;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int NWL    = 1 << ROW_W;
  localparam int NHI    = 1 << HI_W;
  localparam int NMID   = 1 << MID_W;
  localparam int NLO    = 1 << LO_W;
  localparam int NCOL   = 1 << COL_W;

  logic              pulse_q;
  logic [ADDR_W-1:0] held;
  logic              start;
  logic [ADDR_W-1:0] sel;
  logic [ROW_W-1:0]  row;
  logic              fire;
  logic [NHI-1:0]    pre_hi;
  logic [NMID-1:0]   pre_mid;
  logic [NLO-1:0]    pre_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      held    <= '0;
    end else begin
      pulse_q <= vcp;
      if (start) held <= addr;
    end
  end

  assign start = vcp & ~pulse_q;
  assign sel   = start ? addr : held;
  assign row   = sel[ADDR_W-1:COL_W];
  assign fire  = vcp & en;

  for (genvar h = 0; h < NHI; h++) begin : g_hi
    assign pre_hi[h] = fire & (row[ROW_W-1 -: HI_W] == HI_W'(h));
  end

  for (genvar m = 0; m < NMID; m++) begin : g_mid
    assign pre_mid[m] = (row[LO_W +: MID_W] == MID_W'(m));
  end

  for (genvar l = 0; l < NLO; l++) begin : g_lo
    assign pre_lo[l] = (row[LO_W-1:0] == LO_W'(l));
  end

  for (genvar i = 0; i < NWL; i++) begin : g_wl
    assign wl[i] = pre_hi[i / (NMID * NLO)] & pre_mid[(i / NLO) % NMID] & pre_lo[i % NLO];
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign col_sel[c] = en & (sel[COL_W-1:0] == COL_W'(c));
  end

endmodule

module row_pulse_decoder_chk #(
  parameter int ROW_W = 7,
  parameter int COL_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ROW_W+COL_W-1:0]   addr,
  input logic                     vcp,
  input logic                     en,
  input logic [(1<<ROW_W)-1:0]    wl,
  input logic [(1<<COL_W)-1:0]    col_sel
);

  localparam int NWL = 1 << ROW_W;

  // R1
  row_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vcp) && en) |-> (wl == (NWL'(1) << addr[ROW_W+COL_W-1:COL_W])));

  // R2
  wl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vcp |-> (wl == '0));

  // R3
  wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wl));

  // R4
  col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(col_sel) == 1));

  // R5
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (wl == '0 && col_sel == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcp && en && $past(vcp) && $past(en) && $past(rst_n)) |-> ($stable(wl) && $stable(col_sel)));

endmodule

bind row_pulse_decoder row_pulse_decoder_chk #(.ROW_W(HI_W+MID_W+LO_W), .COL_W(COL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .vcp(vcp), .en(en), .wl(wl), .col_sel(col_sel)
);

// File: tb/test_row_pulse_decoder.sv
module test_row_pulse_decoder;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic         vcp = 1'b0;
  logic         en = 1'b0;
  logic [127:0] wl;
  logic [7:0]   col_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  row_pulse_decoder i_row_pulse_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .vcp(vcp), .en(en),
    .wl(wl), .col_sel(col_sel)
  );

  // {addr, en, expected row, expected column}
  localparam logic [20:0] VEC [10] = '{
    {10'h000, 1'b1, 7'd0,   3'd0},
    {10'h3FF, 1'b1, 7'd127, 3'd7},
    {10'h008, 1'b1, 7'd1,   3'd0},
    {10'h007, 1'b1, 7'd0,   3'd7},
    {10'h155, 1'b1, 7'd42,  3'd5},
    {10'h2AA, 1'b1, 7'd85,  3'd2},
    {10'h1F8, 1'b1, 7'd63,  3'd0},
    {10'h200, 1'b1, 7'd64,  3'd0},
    {10'h0AB, 1'b0, 7'd21,  3'd3},
    {10'h3C3, 1'b1, 7'd120, 3'd3}
  };

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] wl_of(input logic e, input int r);
    return e ? (128'd1 << r) : 128'd0;
  endfunction

  function automatic logic [127:0] col_of(input logic e, input int c);
    return e ? (128'd1 << c) : 128'd0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    #2;
    check("R7 wl after reset", wl, '0);
    check("R7 col after reset", {120'd0, col_sel}, 128'd1);

    for (int v = 0; v < 10; v++) begin
      logic [9:0] a;
      logic       e;
      int         r;
      int         c;
      a = VEC[v][20:11];
      e = VEC[v][10];
      r = int'(VEC[v][9:3]);
      c = int'(VEC[v][2:0]);
      @(negedge clk);
      addr = a; en = e; vcp = 1'b1;
      #2;
      check(e ? "R1 wl" : "R5 wl", wl, wl_of(e, r));
      check(e ? "R4 col" : "R5 col", {120'd0, col_sel}, col_of(e, c));
      @(negedge clk);
      addr = ~a;
      #2;
      check("R6 wl held", wl, wl_of(e, r));
      check("R6 col held", {120'd0, col_sel}, col_of(e, c));
      @(negedge clk);
      vcp = 1'b0;
      #2;
      check("R2 wl idle", wl, '0);
    end

    // R9: column of last capture visible between pulses
    en = 1'b1;
    @(negedge clk);
    addr = 10'h3A5;
    #2;
    check("R9 col between pulses", {120'd0, col_sel}, 128'd1 << 3);
    check("R2 wl idle with addr change", wl, '0);

    // R8: back-to-back pulses with one low cycle
    @(negedge clk);
    addr = 10'h0D1; vcp = 1'b1;
    #2;
    check("R8 first pulse", wl, 128'd1 << 26);
    @(negedge clk);
    vcp = 1'b0;
    @(negedge clk);
    addr = 10'h2F6; vcp = 1'b1;
    #2;
    check("R8 second pulse", wl, 128'd1 << 94);
    check("R3 one line", 128'($countones(wl)), 128'd1);
    check("R8 second col", {120'd0, col_sel}, 128'd1 << 6);

    // R5: enable drop mid-pulse, then return
    @(negedge clk);
    en = 1'b0;
    #2;
    check("R5 wl off mid-pulse", wl, '0);
    check("R5 col off mid-pulse", {120'd0, col_sel}, '0);
    @(negedge clk);
    en = 1'b1; addr = 10'h000;
    #2;
    check("R6 held after enable return", wl, 128'd1 << 94);
    @(negedge clk);
    vcp = 1'b0;
    #2;
    check("R2 wl end", wl, '0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule